// File: doc/BRIEF.md
# Split-Half Register File

This block is the register storage for a 32-bit datapath: sixteen entries, two read ports and one write port. Each entry is held as two separate 16-bit halves, an upper bank for bits 31..16 and a lower bank for bits 15..0, and each bank has its own write enable. Because of this split, a constant-load operation can fill the lower half and clear the upper half in one write. It can also place a 16-bit constant in the upper half without disturbing the lower half, with no read-modify-write cycle.

A write is presented as an enable, an address, 32 bits of data and a two-bit mode. Each read port takes an address and returns the entry on a registered output one clock later, which matches the timing of a synchronous RAM. Entry 0 is hard-wired to zero. The storage itself is never reset. Only the read output registers are cleared, by an asynchronous active-low reset whose release is synchronised inside the block.

Top module: `srf_regfile`

## Requirements
- R1: With mode 2'b00 (full) and `wr_en` high, all 32 bits of `wr_data` are stored in entry `wr_addr` for any address 1..15, and can be read back unchanged.
- R2: Entry 0 always reads as zero on both ports, whatever write has been aimed at it in any mode.
- R3: The two read ports are independent: in the same cycle, port A and port B return the contents of two different entries, each selected by its own address.
- R4: With mode 2'b01 (load-low), `wr_data[15:0]` is written into bits 15..0 and bits 31..16 become zero; `wr_data[31:16]` is ignored.
- R5: With mode 2'b10 (load-high), `wr_data[15:0]` is written into bits 31..16 and bits 15..0 keep their previous value.
- R6: A read address present at a rising clock edge produces that entry's data on the read output right after that edge (one cycle of latency), and a write done at an edge is visible to a read taken at the next edge.
- R7: A read of the entry being written at the same edge returns the value from before the write.
- R8: When `wr_en` is low, or when the mode is 2'b11 (reserved), no entry changes.
- R9: While `rst_n` is low, both read outputs are zero. After `rst_n` rises they stay zero for two more clock edges and then follow the read addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset for the read output registers |
| wr_en | input | 1 | Write enable |
| wr_mode | input | 2 | 00 full, 01 load-low, 10 load-high, 11 no write |
| wr_addr | input | 4 | Entry to write |
| wr_data | input | 32 | Write data; only bits 15..0 are used by the two load modes |
| rd_addr_a | input | 4 | Read address, port A |
| rd_addr_b | input | 4 | Read address, port B |
| rd_data_a | output | 32 | Registered read data, port A |
| rd_data_b | output | 32 | Registered read data, port B |

## Verification
The in-RTL assertions check four things on every cycle:
- an address of zero on either port gives a zero output after one edge;
- a load-low write followed by a read of the same entry returns the constant in the lower half and zero in the upper half;
- a load-high write places the constant in the upper half;
- the outputs are cleared while reset is low.

Other properties depend on the history of an entry, so only the bench's sweeps can show them. These are that the lower half survives a load-high, that a disabled or reserved-mode write changes nothing, and that a read hitting the entry being written returns the old value. The bench covers them by writing every entry in every mode, with a model that computes the expected halves arithmetically.

// File: rtl/srf_pkg.sv
package srf_pkg;
  typedef enum logic [1:0] {
    WM_FULL    = 2'b00,
    WM_LOAD_LO = 2'b01,
    WM_LOAD_HI = 2'b10,
    WM_NONE    = 2'b11
  } wmode_e;
endpackage

// File: rtl/srf_rst_sync.sv
// Asynchronous assertion, synchronous two-stage release.
module srf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/srf_half_bank.sv
// One half-width bank: NREGS entries, one write port, two combinational
// read ports. Entry 0 is a constant zero and holds no storage.
module srf_half_bank #(
  parameter int NREGS = 16,
  parameter int HW    = 16,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [HW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [HW-1:0] rdata_a,
  output logic [HW-1:0] rdata_b
);
  logic [HW-1:0] ent [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_ent
    if (g == 0) begin : g_zero
      assign ent[g] = '0;
    end else begin : g_store
      logic          hit;
      logic [HW-1:0] q;
      logic [HW-1:0] q_nxt;

      always_comb begin
        hit   = we && (waddr == AW'(g));
        q_nxt = hit ? wdata : q;
      end

      always_ff @(posedge clk) begin
        q <= q_nxt;
      end

      assign ent[g] = q;
    end
  end

  always_comb begin
    rdata_a = ent[raddr_a];
    rdata_b = ent[raddr_b];
  end
endmodule

// File: rtl/srf_read_port.sv
// Output register of one read port: joins the two halves, cleared on reset.
module srf_read_port #(
  parameter int HW = 16,
  localparam int DW = 2 * HW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] hi_in,
  input  logic [HW-1:0] lo_in,
  output logic [DW-1:0] data_q
);
  logic [DW-1:0] data_d;

  always_comb begin
    data_d = {hi_in, lo_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end
endmodule

// File: rtl/srf_regfile.sv
module srf_regfile #(
  parameter int NREGS = 16,
  parameter int DW    = 32,
  localparam int AW   = $clog2(NREGS),
  localparam int HW   = DW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_mode,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [DW-1:0] rd_data_a,
  output logic [DW-1:0] rd_data_b
);
  import srf_pkg::*;

  logic          rst_sync_n;
  wmode_e        mode;
  logic          wr_ok;
  logic          hi_we, lo_we;
  logic [HW-1:0] hi_wdata, lo_wdata;
  logic [HW-1:0] hi_a, hi_b, lo_a, lo_b;

  srf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Write decode: each mode sets the enable and data of both halves.
  always_comb begin
    mode     = wmode_e'(wr_mode);
    wr_ok    = wr_en && (wr_addr != '0);
    hi_we    = 1'b0;
    lo_we    = 1'b0;
    hi_wdata = wr_data[DW-1:HW];
    lo_wdata = wr_data[HW-1:0];
    unique case (mode)
      WM_FULL: begin
        hi_we = wr_ok;
        lo_we = wr_ok;
      end
      WM_LOAD_LO: begin
        hi_we    = wr_ok;
        lo_we    = wr_ok;
        hi_wdata = '0;
      end
      WM_LOAD_HI: begin
        hi_we    = wr_ok;
        hi_wdata = wr_data[HW-1:0];
      end
      WM_NONE: begin
        hi_we = 1'b0;
        lo_we = 1'b0;
      end
    endcase
  end

  srf_half_bank #(.NREGS(NREGS), .HW(HW)) u_hi (
    .clk     (clk),
    .we      (hi_we),
    .waddr   (wr_addr),
    .wdata   (hi_wdata),
    .raddr_a (rd_addr_a),
    .raddr_b (rd_addr_b),
    .rdata_a (hi_a),
    .rdata_b (hi_b)
  );

  srf_half_bank #(.NREGS(NREGS), .HW(HW)) u_lo (
    .clk     (clk),
    .we      (lo_we),
    .waddr   (wr_addr),
    .wdata   (lo_wdata),
    .raddr_a (rd_addr_a),
    .raddr_b (rd_addr_b),
    .rdata_a (lo_a),
    .rdata_b (lo_b)
  );

  srf_read_port #(.HW(HW)) u_port_a (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .hi_in  (hi_a),
    .lo_in  (lo_a),
    .data_q (rd_data_a)
  );

  srf_read_port #(.HW(HW)) u_port_b (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .hi_in  (hi_b),
    .lo_in  (lo_b),
    .data_q (rd_data_b)
  );

  // R2: address zero yields zero on the following cycle, both ports
  a_r2_zero_port_a: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_addr_a == '0) |=> (rd_data_a == '0));
  a_r2_zero_port_b: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_addr_b == '0) |=> (rd_data_b == '0));

  // R4: load-low, then a read of that entry, gives {zero, constant}
  a_r4_load_low: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_mode == 2'b01 && wr_addr != '0) |=>
      ((rd_addr_a == $past(wr_addr)) |=>
        (rd_data_a == {{HW{1'b0}}, $past(wr_data[HW-1:0], 2)})));

  // R5: load-high places the constant in the upper half
  a_r5_load_high: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_mode == 2'b10 && wr_addr != '0) |=>
      ((rd_addr_a == $past(wr_addr)) |=>
        (rd_data_a[DW-1:HW] == $past(wr_data[HW-1:0], 2))));

  // R9: outputs are cleared while reset is held
  a_r9_reset_clear: assert property (@(posedge clk)
    (!rst_n) |=> (rd_data_a == '0 && rd_data_b == '0));
endmodule

// File: tb/srf_regfile_tb.sv
module srf_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_mode;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  rd_addr_a, rd_addr_b;
  logic [31:0] rd_data_a, rd_data_b;

  int          n_tests = 0;
  int          n_fail  = 0;
  bit          done    = 1'b0;
  logic [31:0] model [16];

  always #4 clk = ~clk;

  srf_regfile dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_mode   (wr_mode),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr_a (rd_addr_a),
    .rd_addr_b (rd_addr_b),
    .rd_data_a (rd_data_a),
    .rd_data_b (rd_data_b)
  );

  function automatic logic [31:0] pat(input int i);
    return 32'h9E37_79B9 * (i + 1);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one cycle, predict the outputs from the model before the write,
  // update the model, then sample after the edge.
  task automatic step(input logic we, input logic [1:0] md, input int wa,
                      input logic [31:0] wd, input int ra, input int rb,
                      input string tag);
    logic [31:0] ea, eb;
    @(negedge clk);
    wr_en = we; wr_mode = md; wr_addr = 4'(wa); wr_data = wd;
    rd_addr_a = 4'(ra); rd_addr_b = 4'(rb);
    ea = model[ra];
    eb = model[rb];
    if (we && wa != 0) begin
      case (md)
        2'b00: model[wa] = wd;
        2'b01: model[wa] = {16'h0000, wd[15:0]};
        2'b10: model[wa] = {wd[15:0], model[wa][15:0]};
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " port A"}, rd_data_a, ea);
    check({tag, " port B"}, rd_data_b, eb);
    wr_en = 1'b0;
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 16; i++) step(1'b0, 2'b00, 0, 32'h0, i, 15 - i, tag);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 32'h0;
    rst_n = 1'b0; wr_en = 1'b0; wr_mode = 2'b00; wr_addr = '0; wr_data = '0;
    rd_addr_a = 4'd3; rd_addr_b = 4'd7;
    repeat (3) begin
      @(negedge clk);
      check("R9 reset A", rd_data_a, 32'h0);
      check("R9 reset B", rd_data_b, 32'h0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 release A", rd_data_a, 32'h0);
    repeat (3) @(negedge clk);

    // R1: full writes everywhere, including entry 0 (R2)
    for (int i = 0; i < 16; i++) step(1'b1, 2'b00, i, pat(i), 0, 0, "R1 full write");
    sweep("R1 R2 R3 readback");

    // R7: read hits the entry being written -> old value
    for (int i = 1; i < 16; i++) step(1'b1, 2'b00, i, ~pat(i), i, 0, "R7 old value");
    sweep("R7 R3 after");

    // R6: new value is visible one edge later
    step(1'b1, 2'b00, 5, 32'hCAFE_F00D, 5, 4, "R6 write");
    step(1'b0, 2'b00, 0, 32'h0, 5, 6, "R6 next read");

    // R4: load-low with junk in the upper data bits
    for (int i = 0; i < 16; i++)
      step(1'b1, 2'b01, i, 32'hBEEF_0000 | (i * 32'h1111), (i + 15) % 16, i, "R4 load low");
    sweep("R4 readback");

    // R5: load-high keeps the lower halves from R4
    for (int i = 0; i < 16; i++)
      step(1'b1, 2'b10, i, {16'hDEAD, 16'(i * 16'h0707 + 3)}, i, (i + 1) % 16, "R5 load high");
    sweep("R5 readback");

    // R8: disabled and reserved-mode writes change nothing
    for (int i = 0; i < 16; i++) step(1'b0, 2'b00, i, 32'hFFFF_FFFF, i, 0, "R8 disabled");
    for (int i = 0; i < 16; i++) step(1'b1, 2'b11, i, 32'h1234_5678, i, 0, "R8 reserved");
    sweep("R8 readback");

    // R2: loads aimed at entry 0
    step(1'b1, 2'b01, 0, 32'h0000_ABCD, 0, 0, "R2 load low to 0");
    step(1'b1, 2'b10, 0, 32'h0000_ABCD, 0, 0, "R2 load high to 0");
    step(1'b0, 2'b00, 0, 32'h0, 0, 0, "R2 read 0");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule